// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

After a single start pulse, this block runs the bring-up sequence that a DDR2 device needs before normal traffic. It produces one memory command at a time and works through each chip select in turn, from chip 0 up to and including a chosen last chip. Each chip receives thirteen commands. They cover:

- precharging and refreshing the device;
- writing the three extended mode registers;
- writing the mode register twice, first with the DLL reset bit set and then with it cleared;
- entering and then leaving off-chip-driver calibration.

Fixed pauses of `WAIT_CYCLES` clock cycles are placed after four of the steps. During a pause no command is offered.

Commands leave the block on a valid/ready interface. The command issuer downstream raises ready when it accepts a command. The command appears both as separate fields and as one packed word, so a controller that expects the packed form can use the word directly. A done flag rises once the last command of the last chip has been accepted. The flag stays high until the next start.

Top module: `ddr2_init_seq`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it, `cmd_valid`, `busy` and `done` are low.
- R2: When `start` is sampled high while the block is not busy, `busy` and `cmd_valid` are high on the next cycle, and the first command is a NOP (type 3) to chip select 0.
- R3: Each chip receives exactly these 13 commands, in this order: NOP, precharge-all, EMR2 write, EMR3 write, EMR1 write, MR write with DLL reset, precharge-all, auto-refresh, auto-refresh, auto-refresh, MR write without DLL reset, EMR1 write with calibration default, EMR1 write with calibration exit.
- R4: Both MR writes use bank 0. The first value is 0x742: burst length code 010 in bits 2:0, sequential burst in bit 3, CAS latency code 100 in bits 6:4, test mode off in bit 7, DLL reset in bit 8, and write recovery code 011 in bits 11:9. The second value is 0x642, which is the same with bit 8 cleared.
- R5: The EMR2 and EMR3 writes use banks 2 and 3 with value 0. Every EMR1 write uses bank 1. The first EMR1 write has value 0. The calibration-default write has value 0x384: calibration field bits 9:7 = 111, 75-ohm termination in bit 2, and full drive strength with bit 1 = 0. The calibration-exit write has value 0x004, with bits 9:7 = 000.
- R6: The type codes are 0 = precharge-all, 1 = auto-refresh, 2 = mode or extended-mode register write, 3 = NOP. `cmd_word` packs the chip select in bits 21:20, the type in 19:18, the bank in 17:16 and the value in 15:0. Commands other than type 2 carry bank 0 and value 0.
- R7: After each of these commands is accepted, `cmd_valid` stays low for exactly `WAIT_CYCLES` cycles: the first precharge-all, the second auto-refresh, the MR write without DLL reset, and the calibration-default write. After every other accepted command, the next command is valid on the very next cycle.
- R8: A command moves on only in a cycle where `cmd_valid` and `cmd_ready` are both high. While ready is low, the command stays valid and does not change.
- R9: The sequence runs for chip selects 0 through `max_chip` in ascending order. `max_chip` is captured at start, so changing it later has no effect on the run in progress.
- R10: On the cycle after the last command of the last chip is accepted, `done` is high and `busy` is low. `done` stays high until the next start.
- R11: A `start` pulse while `busy` is high is ignored. The command stream carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin the sequence |
| max_chip | input | 2 | Index of the last chip select to initialize, captured at start |
| cmd_ready | input | 1 | Command issuer accepts the current command |
| cmd_valid | output | 1 | A command is offered |
| cmd_type | output | 2 | Command type code |
| cmd_cs | output | 2 | Target chip select |
| cmd_bank | output | 2 | Bank address |
| cmd_addr | output | 16 | Address or mode register value |
| cmd_word | output | 22 | Packed form of chip select, type, bank and value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Whole sequence finished |

## Verification
Every output comes from a register, so a change at a clock edge is seen one cycle later:

- The first command follows the edge that samples `start`.
- `done` follows the edge that accepts the final command.
- After a pause step, the next command arrives `WAIT_CYCLES` cycles after the accepting edge.

The bench drives its inputs just after each rising edge and samples on the falling edge. It records every accepted command, together with the number of cycles in which nothing was valid since the previous one. It then compares the whole stream for each chip against an expected list. That list is built by a bench function from the field values given in the requirements. The bench also checks at each sample that a command held by a low ready is unchanged, and it checks `done` on the sample right after the final acceptance.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int WAIT_CYCLES = 16,
  parameter int CHIP_W      = 2,
  parameter int BANK_W      = 2,
  parameter int ADDR_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CHIP_W-1:0]   max_chip,
  input  logic                cmd_ready,
  output logic                cmd_valid,
  output logic [1:0]          cmd_type,
  output logic [CHIP_W-1:0]   cmd_cs,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [CHIP_W+BANK_W+ADDR_W+1:0] cmd_word,
  output logic                busy,
  output logic                done
);

  localparam int STEPS  = 13;
  localparam int STEP_W = $clog2(STEPS);
  localparam int CNT_W  = $clog2(WAIT_CYCLES + 1);

  localparam logic [1:0] T_PRE = 2'd0;
  localparam logic [1:0] T_REF = 2'd1;
  localparam logic [1:0] T_MRS = 2'd2;
  localparam logic [1:0] T_NOP = 2'd3;

  localparam logic [ADDR_W-1:0] MR_DLL  = ADDR_W'({3'b011, 1'b1, 1'b0, 3'b100, 1'b0, 3'b010});
  localparam logic [ADDR_W-1:0] MR_RUN  = ADDR_W'({3'b011, 1'b0, 1'b0, 3'b100, 1'b0, 3'b010});
  localparam logic [ADDR_W-1:0] EMR_CAL = ADDR_W'({3'b111, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0});
  localparam logic [ADDR_W-1:0] EMR_END = ADDR_W'({3'b000, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0});

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT} state_t;

  state_t              st;
  logic [STEP_W-1:0]   step;
  logic [CHIP_W-1:0]   chip, last_chip;
  logic [CNT_W-1:0]    wcnt;
  logic                done_q;
  logic                pause_after;
  logic [1:0]          typ;
  logic [BANK_W-1:0]   bnk;
  logic [ADDR_W-1:0]   val;

  wire fire      = cmd_valid & cmd_ready;
  wire last_step = (int'(step) == STEPS - 1);

  always_comb begin
    typ = T_NOP;
    bnk = '0;
    val = '0;
    pause_after = 1'b0;
    case (int'(step))
      0:       typ = T_NOP;
      1:       begin typ = T_PRE; pause_after = 1'b1; end
      2:       begin typ = T_MRS; bnk = BANK_W'(2); end
      3:       begin typ = T_MRS; bnk = BANK_W'(3); end
      4:       begin typ = T_MRS; bnk = BANK_W'(1); end
      5:       begin typ = T_MRS; val = MR_DLL; end
      6:       typ = T_PRE;
      7:       typ = T_REF;
      8:       begin typ = T_REF; pause_after = 1'b1; end
      9:       typ = T_REF;
      10:      begin typ = T_MRS; val = MR_RUN; pause_after = 1'b1; end
      11:      begin typ = T_MRS; bnk = BANK_W'(1); val = EMR_CAL; pause_after = 1'b1; end
      12:      begin typ = T_MRS; bnk = BANK_W'(1); val = EMR_END; end
      default: typ = T_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      step      <= '0;
      chip      <= '0;
      last_chip <= '0;
      wcnt      <= '0;
      done_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_CMD;
          step      <= '0;
          chip      <= '0;
          last_chip <= max_chip;
          done_q    <= 1'b0;
        end
        S_CMD: if (fire) begin
          if (last_step) begin
            step <= '0;
            if (chip == last_chip) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              chip <= chip + 1'b1;
            end
          end else begin
            step <= step + 1'b1;
            if (pause_after) begin
              st   <= S_WAIT;
              wcnt <= CNT_W'(WAIT_CYCLES - 1);
            end
          end
        end
        S_WAIT: begin
          if (wcnt == '0) st <= S_CMD;
          else            wcnt <= wcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == S_CMD);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign cmd_type  = typ;
  assign cmd_cs    = chip;
  assign cmd_bank  = bnk;
  assign cmd_addr  = val;
  assign cmd_word  = {chip, typ, bnk, val};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !cmd_valid && !busy && !done);

  a_r2_first_nop: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> cmd_valid && cmd_type == T_NOP && cmd_cs == '0);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));

  a_r6_plain_fields: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_type != T_MRS |-> cmd_addr == '0 && cmd_bank == '0);

  a_r9_cs_bound: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_cs <= last_chip);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !cmd_valid);

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
  localparam int WAITC = 16;
  localparam int NCMD  = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  max_chip = 2'd0;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid;
  logic [1:0]  cmd_type, cmd_cs, cmd_bank;
  logic [15:0] cmd_addr;
  logic [21:0] cmd_word;
  logic        busy, done;

  ddr2_init_seq #(.WAIT_CYCLES(WAITC)) u_dut (
    .clk(clk), .rst(rst), .start(start), .max_chip(max_chip),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_word(cmd_word), .busy(busy), .done(done));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit rand_ready = 1'b0;
  logic [21:0] cap_word [0:63];
  int          cap_gap  [0:63];
  int cap_n = 0, gap = 0, exp_total = 0;
  bit done_due = 1'b0;
  logic        pv = 1'b0, pr = 1'b0;
  logic [21:0] pw = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_word(input int idx, input int cs);
    logic [1:0] t; logic [1:0] b; logic [15:0] v;
    t = 2'd2; b = 2'd0; v = 16'h0;
    case (idx)
      0: t = 2'd3;
      1, 6: t = 2'd0;
      2: b = 2'd2;
      3: b = 2'd3;
      4: b = 2'd1;
      5: v = 16'h0742;
      7, 8, 9: t = 2'd1;
      10: v = 16'h0642;
      11: begin b = 2'd1; v = 16'h0384; end
      12: begin b = 2'd1; v = 16'h0004; end
      default: t = 2'd3;
    endcase
    return {2'(cs), t, b, v};
  endfunction

  function automatic int exp_gap(input int idx);
    return (idx == 2 || idx == 9 || idx == 11 || idx == 12) ? WAITC : 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    #1;
    cmd_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done_due) begin
        check(done && !busy, "R10 done after final accept", {busy, done}, 2'b01);
        done_due = 1'b0;
      end
      if (pv && !pr)
        check(cmd_valid && cmd_word == pw, "R8 held command", {cmd_valid, cmd_word}, {1'b1, pw});
      if (cmd_valid && cmd_ready) begin
        if (cap_n < 64) begin
          cap_word[cap_n] = cmd_word;
          cap_gap[cap_n]  = gap;
        end
        cap_n++;
        gap = 0;
        if (cap_n == exp_total) done_due = 1'b1;
      end else if (!cmd_valid && busy) begin
        gap++;
      end
    end
    pv = cmd_valid; pr = cmd_ready; pw = cmd_word;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    check(1'b0, "watchdog", cycles, 150000);
    summary();
  end

  task automatic begin_run(input logic [1:0] mc);
    cap_n = 0; gap = 0;
    exp_total = NCMD * (int'(mc) + 1);
    @(posedge clk); #1;
    start = 1'b1; max_chip = mc;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(busy && cmd_valid && cmd_type == 2'd3 && cmd_cs == 2'd0, "R2 first NOP",
          {busy, cmd_valid, cmd_type, cmd_cs}, 6'b111100);
  endtask

  task automatic finish_run(input int nchips, input string tag);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done, {"R10 done reached ", tag}, done, 1);
    check(cap_n == NCMD * nchips, {"R9 command count ", tag}, cap_n, NCMD * nchips);
    for (int i = 0; i < cap_n && i < 64; i++) begin
      check(cap_word[i] == exp_word(i % NCMD, i / NCMD), "R3 R4 R5 R6 command word",
            cap_word[i], exp_word(i % NCMD, i / NCMD));
      check(cap_gap[i] == exp_gap(i % NCMD), "R7 pause length", cap_gap[i], exp_gap(i % NCMD));
    end
    repeat (3) @(negedge clk);
    check(done && !busy, "R10 done held", {busy, done}, 2'b01);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cmd_valid && !busy && !done, "R1 in reset", {cmd_valid, busy, done}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!cmd_valid && !busy && !done, "R1 after reset", {cmd_valid, busy, done}, 0);

    begin_run(2'd0);
    finish_run(1, "single chip");

    rand_ready = 1'b1;
    begin_run(2'd3);
    @(posedge clk); #1 max_chip = 2'd0;
    repeat (25) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (200) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    finish_run(4, "four chips R11 start ignored");

    begin_run(2'd1);
    finish_run(2, "two chips random ready");

    rand_ready = 1'b0;
    begin_run(2'd2);
    repeat (10) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!cmd_valid && !busy && !done, "R1 reset mid run", {cmd_valid, busy, done}, 0);
    exp_total = 0;

    summary();
  end
endmodule